// File: doc/BRIEF.md
# L2 Stream Prefetcher

This block sits beside a second-level cache and watches the line addresses of the read requests that reach it. It keeps a small table of tracked streams, one entry per 4 KiB page. When a page shows a run of requests moving steadily up or down, it is confirmed as a stream. The block then issues prefetches for the next lines in that direction. The run-ahead distance is bounded, and a prefetch never crosses the page. An optional spatial mode also requests the partner 64-byte line of every access, so the aligned 128-byte pair is brought in whole.

Addresses are line addresses in 64-byte units. The low six bits select the line within a page, and the upper bits are the page number. Prefetch addresses leave through a valid/ready port. A four-entry queue covers a stalled consumer. Requests arriving while that queue is full lose their prefetches instead of stalling the lookup.

Top module: `l2_stream_prefetcher`

## Requirements
- R1: While reset is asserted and after its release, pf_valid is 0 until a request has been looked up.
- R2: A request trains the table the same way whichever source tag it carries: 0 load, 1 store, 2 first-level prefetch, 3 instruction fetch.
- R3: A page with no table entry gets one on its first request. A move to a different offset sets the direction. A request at an unchanged offset changes nothing. Stream prefetches start only on the second consecutive move in the same direction.
- R4: On each confirmed upward move, up to two lines are offered: base+1 and base+2. The base is the larger of the demand offset and the stream's furthest issued line.
- R5: Confirmed downward streams mirror R4: base-1 and base-2, where the base is the smaller of the demand offset and the furthest issued line.
- R6: A candidate is issued only if its offset lies between 0 and 63. Every prefetch stays in the requesting page.
- R7: A candidate is issued only if it lies no more than 20 lines from the demand offset.
- R8: The furthest issued line of a stream advances to the last candidate issued, even if the queue drops it. A line is never offered twice by one stream while it stays confirmed.
- R9: A move against the recorded direction clears confirmation and records the new direction.
- R10: When spatial_en is 1, every lookup (hit or new allocation) also offers line offset XOR 1. This offer is made only when fewer than two stream candidates were issued and the partner is not already one of them. It is placed after them.
- R11: The table holds 16 pages. A request to an untracked page while the table is full replaces the least recently requested page. Any request to a tracked page counts as use.
- R12: Prefetches leave in issue order through a 4-entry queue. The head and pf_valid hold while pf_ready is 0. A candidate that finds no free slot is dropped; a slot freed by a pop at the same edge counts as free.
- R13: A prefetch accepted from a request sampled at a clock edge is visible on pf_valid/pf_line right after that edge when the queue was empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released on the clock |
| req_valid | input | 1 | A cache request is present this cycle |
| req_line | input | LINE_W | Requested line address (page number above six offset bits) |
| req_src | input | 2 | Source tag of the request |
| spatial_en | input | 1 | Enables the 128-byte pair completion |
| pf_valid | output | 1 | A prefetch address is offered |
| pf_line | output | LINE_W | Offered prefetch line address |
| pf_ready | input | 1 | Consumer takes the offered prefetch |

## Verification
The bench drives streams that end at the top and bottom of a page. A design with a wrong bound check would emit a line of the neighbouring page. It also drives streams that outrun the demand by the full 20 lines; a missing limit would keep offering two lines every step. Reversal, repeated offsets and demand jumps past the frontier expose duplicate or lost prefetches. The eviction test re-touches the oldest page before overflowing the table, so a first-in replacement instead of least-recent would retrain the wrong page. A held consumer with more than four candidates shows whether drops, order and the same-edge pop credit match the queue rules.

// File: rtl/l2pf_pkg.sv
package l2pf_pkg;

  // A 4 KiB page holds 64 lines of 64 bytes.
  localparam int OFF_W      = 6;
  localparam int PAGE_LINES = 1 << OFF_W;

  typedef logic [OFF_W-1:0] off_t;

  typedef enum logic [1:0] {
    SRC_LOAD   = 2'd0,
    SRC_STORE  = 2'd1,
    SRC_L1PF   = 2'd2,
    SRC_IFETCH = 2'd3
  } src_e;

  // Per-page tracking state.
  typedef struct packed {
    logic vld;    // entry in use
    logic dset;   // a direction has been seen
    logic dir;    // 1: ascending
    logic conf;   // stream confirmed
    off_t last;   // last demand offset
    off_t front;  // furthest line issued
  } strm_t;

  typedef struct packed {
    logic vld;
    off_t off;
  } cand_t;

endpackage

// File: rtl/l2pf_step.sv
module l2pf_step
  import l2pf_pkg::*;
#(
  parameter int MAX_AHEAD = 20
) (
  input  strm_t ent_i,
  input  off_t  off_i,
  output strm_t ent_o,
  output cand_t cand0_o,
  output cand_t cand1_o
);

  localparam int SW = OFF_W + 3;
  localparam logic signed [SW-1:0] S_ONE   = SW'(1);
  localparam logic signed [SW-1:0] S_TWO   = SW'(2);
  localparam logic signed [SW-1:0] S_TOP   = SW'(PAGE_LINES - 1);
  localparam logic signed [SW-1:0] S_AHEAD = SW'(MAX_AHEAD);

  logic moved, up_now, same_dir, ok0, ok1;
  logic signed [SW-1:0] o_s, f_s, base_s, c0_s, c1_s;

  function automatic logic in_window(input logic signed [SW-1:0] c,
                                     input logic signed [SW-1:0] o);
    logic signed [SW-1:0] d;
    d = c - o;
    if (d[SW-1]) d = -d;
    return !c[SW-1] && (c <= S_TOP) && (d <= S_AHEAD);
  endfunction

  always_comb begin
    o_s      = $signed({3'b000, off_i});
    f_s      = $signed({3'b000, ent_i.front});
    moved    = (off_i != ent_i.last);
    up_now   = (off_i > ent_i.last);
    same_dir = ent_i.dset && (up_now == ent_i.dir);

    // Resume from the frontier only when it is ahead of the demand.
    base_s = o_s;
    if (ent_i.conf) begin
      if (up_now && (f_s > o_s))       base_s = f_s;
      else if (!up_now && (f_s < o_s)) base_s = f_s;
    end
    c0_s = up_now ? base_s + S_ONE : base_s - S_ONE;
    c1_s = up_now ? base_s + S_TWO : base_s - S_TWO;
    ok0  = in_window(c0_s, o_s);
    ok1  = in_window(c1_s, o_s);

    ent_o   = ent_i;
    cand0_o = '0;
    cand1_o = '0;
    if (moved) begin
      ent_o.last = off_i;
      if (same_dir) begin
        ent_o.conf   = 1'b1;
        cand0_o.vld  = ok0;
        cand0_o.off  = c0_s[OFF_W-1:0];
        cand1_o.vld  = ok1;
        cand1_o.off  = c1_s[OFF_W-1:0];
        ent_o.front  = ok1 ? c1_s[OFF_W-1:0] :
                       ok0 ? c0_s[OFF_W-1:0] : base_s[OFF_W-1:0];
      end else begin
        ent_o.dir  = up_now;
        ent_o.dset = 1'b1;
        ent_o.conf = 1'b0;
      end
    end
  end

endmodule

// File: rtl/l2pf_table.sv
module l2pf_table
  import l2pf_pkg::*;
#(
  parameter int LINE_W    = 26,
  parameter int NSTREAM   = 16,
  parameter int MAX_AHEAD = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_en,
  input  logic [LINE_W-1:0] lk_line,
  input  logic              spatial_en,
  output logic              push0_vld,
  output logic [LINE_W-1:0] push0_line,
  output logic              push1_vld,
  output logic [LINE_W-1:0] push1_line
);

  localparam int PG_W = LINE_W - OFF_W;
  localparam int IW   = $clog2(NSTREAM);
  localparam int AW   = IW + 1;

  typedef logic [PG_W-1:0] page_t;

  strm_t         ent_q  [NSTREAM];
  strm_t         ent_d  [NSTREAM];
  page_t         page_q [NSTREAM];
  page_t         page_d [NSTREAM];
  logic [IW-1:0] age_q  [NSTREAM];
  logic [IW-1:0] age_d  [NSTREAM];

  page_t               lk_page;
  off_t                lk_off, partner, dist0, dist1;
  logic [NSTREAM-1:0]  hit_vec, free_vec;
  logic                hit, any_free, sp_ok;
  logic [IW-1:0]       hit_idx, free_idx, old_idx, sel_idx;
  logic [AW-1:0]       ref_age;
  strm_t               hit_ent, step_ent, new_ent;
  cand_t               sc0, sc1, out0, out1;

  assign lk_page = lk_line[LINE_W-1:OFF_W];
  assign lk_off  = lk_line[OFF_W-1:0];
  assign partner = lk_off ^ off_t'(1);

  for (genvar gi = 0; gi < NSTREAM; gi++) begin : g_match
    assign hit_vec[gi]  = ent_q[gi].vld && (page_q[gi] == lk_page);
    assign free_vec[gi] = !ent_q[gi].vld;
  end

  assign hit      = |hit_vec;
  assign any_free = |free_vec;

  // Lowest index wins for hit and free slot; the oldest page has the top age.
  always_comb begin
    hit_idx  = '0;
    free_idx = '0;
    old_idx  = '0;
    for (int i = NSTREAM - 1; i >= 0; i--) begin
      if (hit_vec[i])                   hit_idx  = IW'(i);
      if (free_vec[i])                  free_idx = IW'(i);
      if (age_q[i] == IW'(NSTREAM - 1)) old_idx  = IW'(i);
    end
  end

  assign hit_ent = ent_q[hit_idx];

  l2pf_step #(.MAX_AHEAD(MAX_AHEAD)) u_step (
    .ent_i   (hit_ent),
    .off_i   (lk_off),
    .ent_o   (step_ent),
    .cand0_o (sc0),
    .cand1_o (sc1)
  );

  always_comb begin
    sel_idx = hit ? hit_idx : (any_free ? free_idx : old_idx);
    if (hit)           ref_age = {1'b0, age_q[hit_idx]};
    else if (any_free) ref_age = AW'(NSTREAM);
    else               ref_age = {1'b0, age_q[old_idx]};
    new_ent       = '0;
    new_ent.vld   = 1'b1;
    new_ent.last  = lk_off;
    new_ent.front = lk_off;
  end

  // Stream candidates first; the pair partner fills a spare slot.
  always_comb begin
    out0  = '0;
    out1  = '0;
    sp_ok = spatial_en && !(hit && sc1.vld) && !(hit && sc0.vld && (sc0.off == partner));
    if (hit && sc0.vld) begin
      out0 = sc0;
      if (sc1.vld)    out1 = sc1;
      else if (sp_ok) out1 = '{vld: 1'b1, off: partner};
    end else if (sp_ok) begin
      out0 = '{vld: 1'b1, off: partner};
    end
  end

  assign push0_vld  = lk_en && out0.vld;
  assign push0_line = {lk_page, out0.off};
  assign push1_vld  = lk_en && out1.vld;
  assign push1_line = {lk_page, out1.off};

  always_comb begin
    ent_d  = ent_q;
    page_d = page_q;
    age_d  = age_q;
    if (lk_en) begin
      for (int i = 0; i < NSTREAM; i++) begin
        if (ent_q[i].vld && ({1'b0, age_q[i]} < ref_age)) age_d[i] = age_q[i] + 1'b1;
      end
      age_d[sel_idx]  = '0;
      page_d[sel_idx] = lk_page;
      ent_d[sel_idx]  = hit ? step_ent : new_ent;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSTREAM; i++) begin
        ent_q[i]  <= '0;
        page_q[i] <= '0;
        age_q[i]  <= '0;
      end
    end else if (lk_en) begin
      ent_q  <= ent_d;
      page_q <= page_d;
      age_q  <= age_d;
    end
  end

  always_comb begin
    dist0 = (out0.off >= lk_off) ? out0.off - lk_off : lk_off - out0.off;
    dist1 = (out1.off >= lk_off) ? out1.off - lk_off : lk_off - out1.off;
  end

  p_single_match_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  p_quiet_until_confirmed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_en && !spatial_en && !(hit && hit_ent.dset)) |-> !push0_vld);

  p_ahead_limit0_r7: assert property (@(posedge clk) disable iff (!rst_n)
    push0_vld |-> (int'(dist0) <= MAX_AHEAD));

  p_ahead_limit1_r7: assert property (@(posedge clk) disable iff (!rst_n)
    push1_vld |-> (int'(dist1) <= MAX_AHEAD));

  p_second_needs_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
    push1_vld |-> push0_vld);

endmodule

// File: rtl/l2pf_queue.sv
module l2pf_queue #(
  parameter int W     = 26,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in0_vld,
  input  logic [W-1:0] in0_data,
  input  logic         in1_vld,
  input  logic [W-1:0] in1_data,
  output logic         out_vld,
  output logic [W-1:0] out_data,
  input  logic         out_rdy
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int SW = CW + 1;

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] head_q, head_d, tail_q, tail_d, wr1_ptr;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [SW-1:0] space;
  logic          pop, acc0, acc1;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign out_vld  = (cnt_q != '0);
  assign out_data = mem_q[head_q];

  always_comb begin
    pop     = out_vld && out_rdy;
    space   = SW'(DEPTH) - {1'b0, cnt_q} + SW'(pop);
    acc0    = in0_vld && (space != '0);
    acc1    = in1_vld && (space > SW'(acc0));
    wr1_ptr = acc0 ? bump(tail_q) : tail_q;
    tail_d  = tail_q;
    if (acc0) tail_d = bump(tail_q);
    if (acc1) tail_d = bump(wr1_ptr);
    head_d  = pop ? bump(head_q) : head_q;
    cnt_d   = cnt_q + CW'(acc0) + CW'(acc1) - CW'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (pop)         head_q <= head_d;
      if (acc0 | acc1) tail_q <= tail_d;
      if (acc0 | acc1 | pop) cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (acc0) mem_q[tail_q]  <= in0_data;
    if (acc1) mem_q[wr1_ptr] <= in1_data;
  end

  p_no_overflow_r12: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) <= DEPTH);

  p_hold_while_stalled_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && !out_rdy) |=> (out_vld && $stable(out_data)));

endmodule

// File: rtl/l2_stream_prefetcher.sv
module l2_stream_prefetcher
  import l2pf_pkg::*;
#(
  parameter int          LINE_W     = 26,
  parameter int          NSTREAM    = 16,
  parameter int          MAX_AHEAD  = 20,
  parameter int          QDEPTH     = 4,
  parameter logic [3:0]  TRAIN_MASK = 4'b1111
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [LINE_W-1:0] req_line,
  input  logic [1:0]        req_src,
  input  logic              spatial_en,
  output logic              pf_valid,
  output logic [LINE_W-1:0] pf_line,
  input  logic              pf_ready
);

  logic [1:0]        rst_pipe;
  logic              rst_core_n, lk_en;
  logic              p0_vld, p1_vld;
  logic [LINE_W-1:0] p0_line, p1_line;
  src_e              src;

  // Reset asserts at once and leaves two edges later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  assign src   = src_e'(req_src);
  assign lk_en = req_valid && TRAIN_MASK[src];

  l2pf_table #(
    .LINE_W    (LINE_W),
    .NSTREAM   (NSTREAM),
    .MAX_AHEAD (MAX_AHEAD)
  ) u_table (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .lk_en      (lk_en),
    .lk_line    (req_line),
    .spatial_en (spatial_en),
    .push0_vld  (p0_vld),
    .push0_line (p0_line),
    .push1_vld  (p1_vld),
    .push1_line (p1_line)
  );

  l2pf_queue #(
    .W     (LINE_W),
    .DEPTH (QDEPTH)
  ) u_queue (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .in0_vld  (p0_vld),
    .in0_data (p0_line),
    .in1_vld  (p1_vld),
    .in1_data (p1_line),
    .out_vld  (pf_valid),
    .out_data (pf_line),
    .out_rdy  (pf_ready)
  );

  p_same_page_r6: assert property (@(posedge clk) disable iff (!rst_core_n)
    p0_vld |-> (p0_line[LINE_W-1:OFF_W] == req_line[LINE_W-1:OFF_W]));

endmodule

// File: tb/tb_l2_stream_prefetcher.sv
module tb_l2_stream_prefetcher;

  localparam int CLK_PERIOD = 10;
  localparam int LINE_W     = 26;
  localparam int OFFB       = 6;
  localparam int PAGE       = 1 << OFFB;
  localparam int NS         = 16;
  localparam int AHEAD      = 20;
  localparam int QD         = 4;
  localparam int WDOG       = 100000;

  logic              clk = 1'b0;
  logic              rst_n, req_valid, spatial_en, pf_ready, pf_valid;
  logic [LINE_W-1:0] req_line, pf_line;
  logic [1:0]        req_src;

  always #(CLK_PERIOD / 2) clk = ~clk;

  l2_stream_prefetcher dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_line   (req_line),
    .req_src    (req_src),
    .spatial_en (spatial_en),
    .pf_valid   (pf_valid),
    .pf_line    (pf_line),
    .pf_ready   (pf_ready)
  );

  int    checks = 0;
  int    fails  = 0;
  int    cyc    = 0;
  string cur_req = "R1";

  typedef struct {
    int page; int last; bit dset; bit dir; bit conf; int front;
  } ment_t;

  ment_t mq[$];   // oldest first
  int    pq[$];   // expected prefetch queue

  function automatic void model_lookup(int line, bit sp);
    int    page, o, idx, base, n, pn;
    bit    up;
    int    c[$];
    ment_t e;
    page = line >> OFFB;
    o    = line & (PAGE - 1);
    idx  = -1;
    foreach (mq[i]) if (mq[i].page == page) idx = i;
    if (idx >= 0) begin
      e = mq[idx];
      mq.delete(idx);
      if (o != e.last) begin
        up = (o > e.last);
        if (e.dset && (up == e.dir)) begin
          if (e.conf) base = up ? ((e.front > o) ? e.front : o) : ((e.front < o) ? e.front : o);
          else        base = o;
          e.conf  = 1'b1;
          e.front = base;
          for (int k = 1; k <= 2; k++) begin
            n = up ? base + k : base - k;
            if (n >= 0 && n < PAGE && ((n > o) ? n - o : o - n) <= AHEAD) begin
              c.push_back(n);
              e.front = n;
            end
          end
        end else begin
          e.dir  = up;
          e.dset = 1'b1;
          e.conf = 1'b0;
        end
        e.last = o;
      end
      mq.push_back(e);
    end else begin
      if (mq.size() == NS) void'(mq.pop_front());
      e = '{page, o, 1'b0, 1'b0, 1'b0, o};
      mq.push_back(e);
    end
    if (sp && c.size() < 2) begin
      pn = o ^ 1;
      if (!(c.size() > 0 && c[0] == pn)) c.push_back(pn);
    end
    foreach (c[i]) if (pq.size() < QD) pq.push_back((page << OFFB) | c[i]);
  endfunction

  function automatic void print_summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endfunction

  // Reference model steps on the same edge as the design.
  always @(posedge clk) begin
    if (!rst_n) begin
      mq.delete();
      pq.delete();
    end else begin
      if (pq.size() > 0 && pf_ready) void'(pq.pop_front());
      if (req_valid) model_lookup(int'(req_line), spatial_en);
    end
  end

  // Compare against the model every cycle, away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      bit exp_v;
      exp_v  = (pq.size() > 0);
      checks++;
      if (pf_valid !== exp_v || (exp_v && pf_line !== LINE_W'(pq[0]))) begin
        fails++;
        $display("FAIL %s: pf_valid/pf_line = %0b/%0h, expected %0b/%0h",
                 cur_req, pf_valid, pf_line, exp_v, exp_v ? pq[0] : 0);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG) begin
      checks++;
      fails++;
      $display("FAIL R13 watchdog: cycles %0d, expected at most %0d", cyc, WDOG);
      print_summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(input int page, input int off, input int src);
    req_valid = 1'b1;
    req_line  = LINE_W'((page << OFFB) | off);
    req_src   = 2'(src);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  int pos[5];

  initial begin
    req_valid  = 1'b0;
    req_line   = '0;
    req_src    = '0;
    spatial_en = 1'b0;
    pf_ready   = 1'b1;
    rst_n      = 1'b0;
    repeat (3) @(negedge clk);
    chk(pf_valid == 1'b0, "R1", pf_valid, 0);
    rst_n = 1'b1;
    idle(3);
    chk(pf_valid == 1'b0, "R1", pf_valid, 0);

    // R2: one stream per source tag
    cur_req = "R2";
    for (int s = 0; s < 4; s++) begin
      for (int k = 5; k < 9; k++) send(100 + s, k, s);
      idle(3);
    end

    // R3: repeats and the confirmation point
    cur_req = "R3";
    send(200, 10, 0); send(200, 10, 1); send(200, 11, 2);
    send(200, 11, 3); idle(2); send(200, 13, 0); idle(4);

    // R4: ascending stream
    cur_req = "R4";
    for (int k = 0; k < 13; k++) begin send(300, k, k % 4); idle(1); end
    idle(4);

    // R5: descending stream
    cur_req = "R5";
    for (int k = 60; k > 44; k--) begin send(301, k, 0); idle(1); end
    idle(4);

    // R6: stream running into the page top and bottom
    cur_req = "R6";
    for (int k = 55; k < 64; k++) begin send(302, k, 1); idle(2); end
    for (int k = 8; k >= 0; k--)  begin send(307, k, 2); idle(2); end
    idle(4);

    // R7: frontier reaches the 20-line cap
    cur_req = "R7";
    for (int k = 0; k < 40; k++) begin send(303, k, 0); idle(2); end
    idle(4);

    // R8: demand behind and ahead of the frontier
    cur_req = "R8";
    send(304, 20, 0); send(304, 21, 0); send(304, 22, 0); idle(3);
    send(304, 23, 0); idle(3); send(304, 23, 0); idle(2);
    send(304, 40, 0); idle(3); send(304, 41, 0); idle(4);

    // R9: direction reversal
    cur_req = "R9";
    for (int k = 10; k < 14; k++) begin send(305, k, 0); idle(2); end
    for (int k = 12; k > 6; k--)  begin send(305, k, 0); idle(2); end
    idle(4);

    // R10: pair completion on misses, hits and confirmed streams
    cur_req = "R10";
    spatial_en = 1'b1;
    send(306, 7, 0); idle(2); send(306, 7, 0); idle(2);
    send(306, 8, 0); idle(2); send(306, 9, 0); idle(3);
    send(306, 10, 0); idle(3); send(308, 62, 1); idle(2);
    for (int k = 40; k < 64; k++) begin send(309, k, 3); idle(2); end
    spatial_en = 1'b0;
    idle(4);

    // R11: sixteen tracked pages, least recent one replaced
    cur_req = "R11";
    for (int p = 400; p < 416; p++) begin send(p, 1, 0); send(p, 2, 0); end
    idle(2);
    send(400, 3, 0); idle(4);
    send(416, 1, 0); idle(1);
    send(400, 4, 0); idle(4);
    send(401, 3, 0); idle(2); send(401, 4, 0); idle(4);

    // R12: stalled consumer, drops and same-edge credit
    cur_req = "R12";
    pf_ready = 1'b0;
    for (int k = 0; k < 8; k++) send(700, k, 0);
    idle(4);
    pf_ready = 1'b1;
    idle(6);
    for (int k = 0; k < 10; k++) begin
      pf_ready = k[0];
      send(701, 2 * k, 1);
    end
    pf_ready = 1'b1;
    idle(8);

    // R13: one-edge latency on an empty queue
    cur_req = "R13";
    spatial_en = 1'b1;
    send(500, 8, 0);
    chk(pf_valid == 1'b1, "R13", pf_valid, 1);
    chk(pf_line == LINE_W'((500 << OFFB) | 9), "R13", pf_line, (500 << OFFB) | 9);
    spatial_en = 1'b0;
    idle(4);

    // Mixed traffic against the model
    cur_req = "R4";
    foreach (pos[i]) pos[i] = 32;
    for (int i = 0; i < 400; i++) begin
      int pg;
      pf_ready   = ($urandom % 4) != 0;
      spatial_en = $urandom % 2;
      pg = $urandom % 5;
      if (pg % 2 == 0) pos[pg] = (pos[pg] + 1 + $urandom % 2) % PAGE;
      else             pos[pg] = (pos[pg] + PAGE - 1 - $urandom % 2) % PAGE;
      if ($urandom % 3 == 0) idle(1);
      else send(600 + pg, pos[pg], $urandom % 4);
    end
    pf_ready   = 1'b1;
    spatial_en = 1'b0;
    idle(10);
    chk(pf_valid == 1'b0, "R12", pf_valid, 0);

    print_summary();
    $finish;
  end

endmodule